// File: doc/BRIEF.md
# Interval Timer Host Programming Interface

This block is the host-facing register front end of a three-channel interval timer. A processor writes bytes over an 8-bit bus, using a two-bit address, an active-low chip select, an active-low write strobe and an active-low read strobe. Address 3 holds the command register. Addresses 0, 1 and 2 take initial-count bytes for channels 0, 1 and 2.

A command byte names its target channel in its top two bits. It sets that channel's byte-access format, its counting mode (0 to 5) and its decimal or binary counting. For that channel it raises a one-cycle reset pulse to the counting engine and rewinds the channel's byte sequencer. Count bytes written later to a channel's address are assembled according to that channel's format. The finished 16-bit value goes out with a one-cycle load strobe.

Two command codes belong to logic outside this block. These are the counter-latch command and the read-back command. They are passed on only as one-cycle flags and leave every channel's setup unchanged.

Top module: `pit_host_regs`

## Requirements
- R1: After reset every channel reports mode 0, binary counting, access format low-byte-only (code 01) and count 0. No reset, load, latch or read-back pulse is active.
- R2: A bus write is a clock edge with cs_n=0, wr_n=0 and rd_n=1. A write to address 3 is a command byte with bits [7:6]=channel, [5:4]=access, [3:1]=mode, [0]=bcd. When the channel field is 0 to 2 and the access field is not 00, that channel's access, mode and bcd take the new values after the edge. Every other channel keeps its setup.
- R3: The mode output is the mode field folded as follows: 000 gives 0, 001 gives 1, x10 gives 2, x11 gives 3, 100 gives 4 and 101 gives 5.
- R4: A command byte with channel field 11 raises readback_req for one cycle. It changes no channel setup and raises no reset pulse.
- R5: A command byte with access field 00 raises latch_req for the named channel for one cycle. It changes no setup, raises no reset pulse and leaves that channel's byte sequencer where it was.
- R6: In access format 01, each count byte d loads count {8'h00, d}, with a load strobe in the cycle after the write.
- R7: In access format 10, each count byte d loads count {d, 8'h00}, with a load strobe in the cycle after the write.
- R8: In access format 11, the first count byte is held with no load strobe. The second byte d2 loads count {d2, first byte}, with a load strobe.
- R9: A setup command for a channel (channel field 0 to 2, access field not 00) raises that channel's reset pulse for one cycle. It also makes the next count byte of that channel the low byte.
- R10: Each channel has its own byte sequencer, so low/high byte pairs for different channels may be interleaved.
- R11: Edges without a bus write (cs_n=1, wr_n=1 or rd_n=0) change no setup, no count and no sequencer state, and raise no pulse.
- R12: Reset, load, latch and read-back pulses last exactly one cycle for a write held for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low; a low level blocks writes |
| addr | input | 2 | Register address: 0 to 2 count bytes, 3 command |
| din | input | 8 | Write data |
| ch_mode | output | 9 | Folded mode, 3 bits per channel |
| ch_bcd | output | 3 | Decimal counting select per channel |
| ch_acc | output | 6 | Access format per channel, 2 bits each |
| ch_rst | output | 3 | One-cycle reset pulse per channel |
| ch_count | output | 48 | Assembled initial count, 16 bits per channel |
| ch_load | output | 3 | One-cycle load strobe per channel |
| latch_req | output | 3 | One-cycle counter-latch flag per channel |
| readback_req | output | 1 | One-cycle read-back flag |

## Verification
All 256 command bytes are written in turn. Each result is compared with an arithmetic model of the field split and the mode fold, and this separates normal setup, latch commands, read-back commands and the don't-care mode bit. Count bytes are then swept under each access format, so a misplaced byte lane or a missing zero fill shows up in the loaded value. Interleaved low/high pairs on two channels, a command that arrives after only the low byte, and a latch command placed between the two bytes separate per-channel sequencers from a shared one and show when the sequencer is rewound. Writes with chip select high, with the write strobe high, or with the read strobe low are followed by a full pair, which would expose any hidden change to the sequencer.

// File: rtl/pit_regs_pkg.sv
`timescale 1ns/1ps
package pit_regs_pkg;

   typedef enum logic [1:0] {
      ACC_LATCH = 2'b00,
      ACC_LO    = 2'b01,
      ACC_HI    = 2'b10,
      ACC_LOHI  = 2'b11
   } acc_e;

   localparam logic [1:0] SEL_READBACK = 2'b11;

   // x10 -> 2, x11 -> 3; the top mode bit only matters when bit 1 is clear
   function automatic logic [2:0] fold_mode(input logic [2:0] m);
      return m[1] ? {1'b0, m[1:0]} : m;
   endfunction

endpackage

// File: rtl/pit_cw_decode.sv
`timescale 1ns/1ps
module pit_cw_decode
   import pit_regs_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [NUM_CH-1:0] cfg_we,
   output logic [NUM_CH-1:0] latch_hit,
   output logic [NUM_CH-1:0] cnt_we,
   output logic              rb_hit,
   output acc_e              cw_acc,
   output logic [2:0]        cw_mode,
   output logic              cw_bcd
);
   localparam logic [ADDR_W-1:0] CMD_ADDR = {ADDR_W{1'b1}};

   logic       is_cmd;
   logic [1:0] sel;

   assign is_cmd  = (addr == CMD_ADDR);
   assign sel     = din[7:6];
   assign cw_acc  = acc_e'(din[5:4]);
   assign cw_mode = fold_mode(din[3:1]);
   assign cw_bcd  = din[0];
   assign rb_hit  = wr_stb && is_cmd && (sel == SEL_READBACK);

   always_comb begin
      cfg_we    = '0;
      latch_hit = '0;
      cnt_we    = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (wr_stb && is_cmd && (sel == 2'(i))) begin
            if (cw_acc == ACC_LATCH) latch_hit[i] = 1'b1;
            else                     cfg_we[i]    = 1'b1;
         end
         if (wr_stb && !is_cmd && (addr == ADDR_W'(i))) cnt_we[i] = 1'b1;
      end
   end

endmodule

// File: rtl/pit_chan_reg.sv
`timescale 1ns/1ps
module pit_chan_reg
   import pit_regs_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cnt_we,
   input  acc_e              cw_acc,
   input  logic [2:0]        cw_mode,
   input  logic              cw_bcd,
   input  logic [DATA_W-1:0] din,
   output logic [2:0]        mode_o,
   output logic              bcd_o,
   output acc_e              acc_o,
   output logic              rst_o,
   output logic [CNT_W-1:0]  count_o,
   output logic              load_o
);
   logic              hi_next_q;   // byte sequencer: 1 = next byte is high
   logic [DATA_W-1:0] lo_hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o    <= 3'd0;
         bcd_o     <= 1'b0;
         acc_o     <= ACC_LO;
         rst_o     <= 1'b0;
         count_o   <= '0;
         load_o    <= 1'b0;
         hi_next_q <= 1'b0;
         lo_hold_q <= '0;
      end else begin
         rst_o  <= cfg_we;
         load_o <= 1'b0;
         if (cfg_we) begin
            mode_o    <= cw_mode;
            bcd_o     <= cw_bcd;
            acc_o     <= cw_acc;
            hi_next_q <= 1'b0;
         end else if (cnt_we) begin
            unique case (acc_o)
               ACC_LO: begin
                  count_o <= {{DATA_W{1'b0}}, din};
                  load_o  <= 1'b1;
               end
               ACC_HI: begin
                  count_o <= {din, {DATA_W{1'b0}}};
                  load_o  <= 1'b1;
               end
               ACC_LOHI: begin
                  if (!hi_next_q) begin
                     lo_hold_q <= din;
                     hi_next_q <= 1'b1;
                  end else begin
                     count_o   <= {din, lo_hold_q};
                     load_o    <= 1'b1;
                     hi_next_q <= 1'b0;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assert_lohi_first_no_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_we && !cfg_we && acc_o == ACC_LOHI && !hi_next_q) |=> !load_o);

   assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_we) |-> $stable({mode_o, bcd_o, acc_o}));

   assert_mode_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_o <= 3'd5);

   assert_acc_not_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      acc_o != ACC_LATCH);

   assert_seq_rewind_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !hi_next_q);

endmodule

// File: rtl/pit_host_regs.sv
`timescale 1ns/1ps
module pit_host_regs
   import pit_regs_pkg::*;
#(
   parameter int NUM_CH = 3,
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cs_n,
   input  logic                      wr_n,
   input  logic                      rd_n,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         din,
   output logic [NUM_CH*3-1:0]       ch_mode,
   output logic [NUM_CH-1:0]         ch_bcd,
   output logic [NUM_CH*2-1:0]       ch_acc,
   output logic [NUM_CH-1:0]         ch_rst,
   output logic [NUM_CH*CNT_W-1:0]   ch_count,
   output logic [NUM_CH-1:0]         ch_load,
   output logic [NUM_CH-1:0]         latch_req,
   output logic                      readback_req
);
   if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_nch
      $error("NUM_CH must be 1..3: the select field has three channel codes");
   end
   if (DATA_W != 8) begin : g_bad_dw
      $error("DATA_W must be 8: command field positions are fixed");
   end
   if (ADDR_W != 2) begin : g_bad_aw
      $error("ADDR_W must be 2");
   end

   logic              wr_stb;
   logic [NUM_CH-1:0] cfg_we, latch_hit, cnt_we;
   logic              rb_hit;
   acc_e              cw_acc;
   logic [2:0]        cw_mode;
   logic              cw_bcd;

   assign wr_stb = !cs_n && !wr_n && rd_n;

   pit_cw_decode #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
      .wr_stb(wr_stb), .addr(addr), .din(din),
      .cfg_we(cfg_we), .latch_hit(latch_hit), .cnt_we(cnt_we), .rb_hit(rb_hit),
      .cw_acc(cw_acc), .cw_mode(cw_mode), .cw_bcd(cw_bcd)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      acc_e acc_w;
      pit_chan_reg #(.DATA_W(DATA_W)) u_ch (
         .clk(clk), .rst_n(rst_n),
         .cfg_we(cfg_we[g]), .cnt_we(cnt_we[g]),
         .cw_acc(cw_acc), .cw_mode(cw_mode), .cw_bcd(cw_bcd), .din(din),
         .mode_o(ch_mode[g*3 +: 3]), .bcd_o(ch_bcd[g]), .acc_o(acc_w),
         .rst_o(ch_rst[g]), .count_o(ch_count[g*CNT_W +: CNT_W]),
         .load_o(ch_load[g])
      );
      assign ch_acc[g*2 +: 2] = acc_w;

      assert_load_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
         ch_load[g] |-> $past(!cs_n && !wr_n && rd_n && addr == ADDR_W'(g)));

      assert_rst_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ch_rst[g] |-> $past(!cs_n && !wr_n && rd_n && addr == {ADDR_W{1'b1}}
                             && din[7:6] == 2'(g) && din[5:4] != 2'b00));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_req    <= '0;
         readback_req <= 1'b0;
      end else begin
         latch_req    <= latch_hit;
         readback_req <= rb_hit;
      end
   end

   assert_rst_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_rst));

   assert_no_write_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || wr_n || !rd_n) |=> (ch_load == '0 && ch_rst == '0
                                   && latch_req == '0 && !readback_req));

   assert_readback_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      readback_req |-> (ch_rst == '0 && latch_req == '0));

endmodule

// File: tb/tb_pit_host_regs.sv
`timescale 1ns/1ps
module tb_pit_host_regs;
   localparam int NCH = 3;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic              rst_n = 1'b0, cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
   logic [1:0]        addr = 2'd0;
   logic [7:0]        din = 8'd0;
   logic [NCH*3-1:0]  ch_mode;
   logic [NCH-1:0]    ch_bcd, ch_rst, ch_load, latch_req;
   logic [NCH*2-1:0]  ch_acc;
   logic [NCH*16-1:0] ch_count;
   logic              readback_req;

   pit_host_regs dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
      .addr(addr), .din(din), .ch_mode(ch_mode), .ch_bcd(ch_bcd),
      .ch_acc(ch_acc), .ch_rst(ch_rst), .ch_count(ch_count),
      .ch_load(ch_load), .latch_req(latch_req), .readback_req(readback_req)
   );

   int total = 0, bad = 0;
   bit finished = 0;

   logic [2:0]  m_mode [NCH];
   logic        m_bcd  [NCH];
   logic [1:0]  m_acc  [NCH];
   logic [15:0] m_cnt  [NCH];
   bit          m_tog  [NCH];
   logic [7:0]  m_lo   [NCH];

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b1; addr = a; din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
   endtask

   task automatic chk_setup(input string tag);
      for (int c = 0; c < NCH; c++) begin
         chk({ch_mode[c*3 +: 3], ch_bcd[c], ch_acc[c*2 +: 2]} ==
             {m_mode[c], m_bcd[c], m_acc[c]}, tag,
             {ch_mode[c*3 +: 3], ch_bcd[c], ch_acc[c*2 +: 2]},
             {m_mode[c], m_bcd[c], m_acc[c]});
      end
   endtask

   task automatic chk_quiet(input string tag);
      @(negedge clk);
      chk({ch_rst, ch_load, latch_req, readback_req} == '0, tag,
          {ch_rst, ch_load, latch_req, readback_req}, 0);
   endtask

   // command write with arithmetic model of the field split
   task automatic cmd(input logic [7:0] v);
      logic [1:0] sc, rw;
      logic [2:0] m, fm;
      logic [NCH-1:0] e_rst, e_lat;
      logic e_rb;
      sc = v[7:6]; rw = v[5:4]; m = v[3:1];
      fm = (m % 4 >= 2) ? 3'(m % 4) : m;
      e_rst = '0; e_lat = '0; e_rb = (sc == 2'd3);
      if (sc != 2'd3) begin
         if (rw == 2'd0) e_lat[sc] = 1'b1;
         else begin
            e_rst[sc] = 1'b1;
            m_mode[sc] = fm; m_bcd[sc] = v[0]; m_acc[sc] = rw; m_tog[sc] = 0;
         end
      end
      bus_wr(2'd3, v);
      chk(ch_rst == e_rst, "R9 reset pulse", ch_rst, e_rst);
      chk(latch_req == e_lat, "R5 latch flag", latch_req, e_lat);
      chk(readback_req == e_rb, "R4 readback flag", readback_req, e_rb);
      chk_setup("R2 R3 setup after command");
      chk_quiet("R12 pulses one cycle after command");
   endtask

   task automatic cnt(input int c, input logic [7:0] d);
      logic [NCH-1:0] e_ld;
      string tag;
      e_ld = '0;
      case (m_acc[c])
         2'd1: begin m_cnt[c] = {8'h00, d}; e_ld[c] = 1'b1; tag = "R6 low-only"; end
         2'd2: begin m_cnt[c] = {d, 8'h00}; e_ld[c] = 1'b1; tag = "R7 high-only"; end
         default: begin
            tag = "R8 R10 low-high";
            if (!m_tog[c]) begin m_lo[c] = d; m_tog[c] = 1; end
            else begin m_cnt[c] = {d, m_lo[c]}; m_tog[c] = 0; e_ld[c] = 1'b1; end
         end
      endcase
      bus_wr(2'(c), d);
      chk(ch_load == e_ld, {tag, " load"}, ch_load, e_ld);
      for (int k = 0; k < NCH; k++)
         chk(ch_count[k*16 +: 16] == m_cnt[k], {tag, " count"},
             ch_count[k*16 +: 16], m_cnt[k]);
   endtask

   task automatic ignored(input logic cs, input logic wr, input logic rd,
                          input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cs_n = cs; wr_n = wr; rd_n = rd; addr = a; din = d;
      @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
      chk({ch_rst, ch_load, latch_req, readback_req} == '0, "R11 no pulse",
          {ch_rst, ch_load, latch_req, readback_req}, 0);
      for (int k = 0; k < NCH; k++)
         chk(ch_count[k*16 +: 16] == m_cnt[k], "R11 count kept",
             ch_count[k*16 +: 16], m_cnt[k]);
      chk_setup("R11 setup kept");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < NCH; c++) begin
         m_mode[c] = 0; m_bcd[c] = 0; m_acc[c] = 2'd1; m_cnt[c] = 0;
         m_tog[c] = 0; m_lo[c] = 0;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_setup("R1 reset setup");
      chk({ch_count, ch_rst, ch_load, latch_req, readback_req} == '0, "R1 reset outputs",
          {ch_rst, ch_load, latch_req, readback_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3 R4 R5 R9: every command byte
      for (int v = 0; v < 256; v++) cmd(8'(v));

      // R6 R7 R8: byte lanes under each format
      for (int c = 0; c < NCH; c++) begin
         cmd({2'(c), 2'b01, 3'd0, 1'b0});
         for (int k = 0; k < 8; k++) cnt(c, 8'(k * 37 + c));
         cmd({2'(c), 2'b10, 3'd2, 1'b1});
         for (int k = 0; k < 8; k++) cnt(c, 8'(255 - k * 29));
         cmd({2'(c), 2'b11, 3'd4, 1'b0});
         for (int k = 0; k < 16; k++) cnt(c, 8'(k * 17 + 3));
      end

      // R10: interleaved pairs on channels 0 and 1
      cmd(8'b00_11_000_0);
      cmd(8'b01_11_010_0);
      cnt(0, 8'h12); cnt(1, 8'h34); cnt(1, 8'h56); cnt(0, 8'h78);
      cnt(1, 8'h9a); cnt(0, 8'hbc); cnt(0, 8'hde); cnt(1, 8'hf0);

      // R9: command after a lone low byte rewinds the sequencer
      cmd(8'b10_11_001_0);
      cnt(2, 8'haa);
      cmd(8'b10_11_001_0);
      cnt(2, 8'h11); cnt(2, 8'h22);
      chk(ch_count[32 +: 16] == 16'h2211, "R9 rewind count", ch_count[32 +: 16], 16'h2211);

      // R5: latch command between the two bytes keeps the sequencer
      cnt(2, 8'h5c);
      cmd(8'b10_00_000_0);
      cnt(2, 8'hc5);
      chk(ch_count[32 +: 16] == 16'hc55c, "R5 latch keeps sequencer",
          ch_count[32 +: 16], 16'hc55c);

      // R4: read-back between the two bytes keeps the sequencer
      cnt(1, 8'h01);
      cmd(8'b11_11_111_1);
      cnt(1, 8'h02);

      // R11: non-writes, then a pair that reveals the sequencer
      cnt(0, 8'h44);
      ignored(1'b1, 1'b0, 1'b1, 2'd0, 8'hee);
      ignored(1'b0, 1'b1, 1'b1, 2'd0, 8'hee);
      ignored(1'b0, 1'b0, 1'b0, 2'd0, 8'hee);
      ignored(1'b1, 1'b0, 1'b1, 2'd3, 8'b00_01_101_1);
      ignored(1'b0, 1'b0, 1'b0, 2'd3, 8'b01_10_011_1);
      cnt(0, 8'h66);
      chk(ch_count[15:0] == 16'h6644, "R11 sequencer kept", ch_count[15:0], 16'h6644);
      chk_quiet("R12 pulses end");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule